// File: doc/BRIEF.md
# Radio Time-Code Clock Serial Responder

This block plays the device side of a radio-synchronised clock that a host reads over a slow asynchronous serial line. It keeps a copy of the current time, date and receiver status. Those values come in on a parallel port and are captured on a load strobe. A separate one-pulse-per-second tick marks the start of each second. Radio reception, calendar stepping and battery sensing all happen outside the block. The block only stores the values it is given and reports them.

Every character that arrives on the receive line is sent back on the transmit line. When a command character is followed directly by a carriage return, the block arms a reply. It does not answer at once. It waits for the next second tick and launches the first start bit on that tick, so the leading edge of the reply marks the second boundary for the host. The reply is 15 encoded characters followed by a carriage return. All of them are built from a snapshot of the stored values taken at the tick that starts the reply.

Control is one state machine with five states:
- `S_IDLE`: nothing is armed and the line is quiet.
- `S_ECHO`: an echo is being sent.
- `S_WAIT`: a query is armed and the line is quiet.
- `S_WAIT_ECHO`: a query is armed while an echo is still being sent.
- `S_REPLY`: the reply is being sent.

Transitions:
- `S_IDLE` goes to `S_WAIT` when a query completes. Otherwise it goes to `S_ECHO` when an echo is pending.
- `S_ECHO` goes to `S_WAIT_ECHO` if a query completes while the transmitter is busy, or to `S_WAIT` if it completes once the transmitter is free. Without a query it returns to `S_IDLE` when the transmitter goes free.
- `S_WAIT` goes to `S_REPLY` on a tick. Otherwise it goes to `S_WAIT_ECHO` when an echo is pending.
- `S_WAIT_ECHO` goes back to `S_WAIT` when the echo ends. A tick in this state is dropped.
- `S_REPLY` sends the characters back to back and returns to `S_IDLE` after the sixteenth.

Top module: `radio_clock_responder`

## Requirements
- R1: After reset the transmit line is high (idle). All stored digits and flags are zero, including the time-valid flag, so a reply before any load carries zero digits and a zero status nibble.
- R2: Every transmitted frame has 11 bits, each lasting `CLKS_PER_BIT` clocks, in this order:
  - a low start bit;
  - 7 data bits, least significant first;
  - a parity bit;
  - two high stop bits.
- R3: Each received character is sent back with the same 7 data bits.
- R4: A reply is armed only when carriage return (0x0D) is received immediately after a character whose low four bits are 1111. Any other character in between prevents arming.
- R5: Once a reply is armed and the transmitter is idle, the start bit of the first reply character appears on the transmit line at the clock edge that samples `tick_i` high. The line stays high before that edge.
- R6: The reply is 16 characters, sent in this order:
  - hour tens, hour units, minute tens, minute units, second tens, second units;
  - day of week;
  - day tens, day units, month tens, month units, year tens, year units;
  - zone character, status character, carriage return.
  
  Each of the first 13 is 0x30 plus a 4-bit field of `time_bcd_i`. Character k takes bits [51-4k : 48-4k].
- R7: The zone character carries these bits:
  - bits 6..3 = 0110;
  - bit 2 = NOT `bst_i`;
  - bit 1 = `bst_i`;
  - bit 0 = `zone_change_i`.
- R8: The status character carries these bits:
  - bits 6..4 = 011;
  - bit 3 = `low_batt_i`;
  - bit 2 = `last_fail_i`;
  - bit 1 = `rx_ok_today_i`;
  - bit 0 = `time_valid_i`.
- R9: Bit 7 of every transmitted character (the parity bit) makes the number of ones in the 8 bits even.
- R10: If an echo is still on the line when a tick arrives with a reply armed, that tick is dropped and the reply starts on a later tick.
- R11: The reply uses the values stored at the tick that starts it. Loads during the reply do not change the characters still to be sent.
- R12: A tick with no armed reply sends nothing.
- R13: Stored values change only in a cycle where `load_i` is high. Changes on the data inputs without a load do not reach the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| tick_i | input | 1 | One-cycle pulse at each second boundary |
| load_i | input | 1 | Capture strobe for the time and flag inputs |
| time_bcd_i | input | 52 | 13 BCD digits, hour tens in bits 51:48 |
| bst_i | input | 1 | Summer time in effect |
| zone_change_i | input | 1 | Zone changeover pending |
| low_batt_i | input | 1 | Low battery flag |
| last_fail_i | input | 1 | Last reception attempt failed |
| rx_ok_today_i | input | 1 | A reception succeeded since 02:30 |
| time_valid_i | input | 1 | Stored time is valid |

## Verification
The checks that run on every cycle cover four things:
- the state machine enters `S_REPLY` only from a sampled tick, with the start bit already low;
- the state machine never leaves `S_WAIT_ECHO` straight into `S_REPLY`;
- the reply snapshot stays frozen for the whole reply;
- the idle line stays high.

Only the bench scenarios can show the rest, by decoding the line: the exact character contents and order, the echo of each received byte, the parity of each byte, that a broken command sequence does not arm, and that a load during the reply has no effect.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    localparam int DATA_BITS   = 7;
    localparam int DIGITS      = 13;
    localparam int DIGIT_W     = 4;
    localparam int BCD_W       = DIGITS * DIGIT_W;
    localparam int REPLY_CHARS = DIGITS + 3;
    localparam int IDX_W       = $clog2(REPLY_CHARS + 1);
    localparam logic [DATA_BITS-1:0] CR_CODE = 7'h0D;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ECHO,
        S_WAIT,
        S_WAIT_ECHO,
        S_REPLY
    } ctl_state_t;

    typedef struct packed {
        logic [BCD_W-1:0] bcd;
        logic             bst;
        logic             change;
        logic             low_batt;
        logic             last_fail;
        logic             ok_today;
        logic             valid;
    } clk_rec_t;

    // Character number idx of the reply, built from one stored record.
    function automatic logic [DATA_BITS-1:0] reply_char(input clk_rec_t r,
                                                        input logic [IDX_W-1:0] idx);
        logic [DATA_BITS-1:0] c;
        if (idx < IDX_W'(DIGITS))
            c = 7'h30 + {3'b000, r.bcd[(DIGITS - 1 - int'(idx)) * DIGIT_W +: DIGIT_W]};
        else if (idx == IDX_W'(DIGITS))
            c = {4'b0110, ~r.bst, r.bst, r.change};
        else if (idx == IDX_W'(DIGITS + 1))
            c = {3'b011, r.low_batt, r.last_fail, r.ok_today, r.valid};
        else
            c = CR_CODE;
        return c;
    endfunction

endpackage

// File: rtl/rcs_uart_rx.sv
module rcs_uart_rx #(
    parameter int CLKS_PER_BIT = 166667
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic       valid_o,
    output logic [6:0] data_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int HALF  = CLKS_PER_BIT / 2;

    logic             s1, s2;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [3:0]       pos;
    logic [6:0]       sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= 1'b1;
            s2      <= 1'b1;
            busy    <= 1'b0;
            cnt     <= '0;
            pos     <= '0;
            sh      <= '0;
            valid_o <= 1'b0;
        end else begin
            s1      <= rx_i;
            s2      <= s1;
            valid_o <= 1'b0;
            if (!busy) begin
                if (!s2) begin
                    busy <= 1'b1;
                    cnt  <= CNT_W'(HALF - 1);
                    pos  <= '0;
                end
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                cnt <= CNT_W'(CLKS_PER_BIT - 1);
                pos <= pos + 1'b1;
                if (pos == 4'd0) begin
                    if (s2) busy <= 1'b0;      // glitch, not a start bit
                end else if (pos <= 4'd7) begin
                    sh <= {s2, sh[6:1]};
                end else if (pos == 4'd9) begin
                    busy    <= 1'b0;
                    valid_o <= s2;             // first stop bit must be high
                end
            end
        end
    end

    assign data_o = sh;

endmodule

// File: rtl/rcs_uart_tx.sv
module rcs_uart_tx #(
    parameter int CLKS_PER_BIT = 166667
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [6:0] data_i,
    output logic       tx_o,
    output logic       busy_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);

    logic [CNT_W-1:0] cnt;
    logic [3:0]       left;
    logic [9:0]       sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_o   <= 1'b1;
            busy_o <= 1'b0;
            cnt    <= '0;
            left   <= '0;
            sh     <= '1;
        end else if (!busy_o) begin
            if (start_i) begin
                tx_o   <= 1'b0;
                sh     <= {2'b11, ^data_i, data_i};
                left   <= 4'd10;
                cnt    <= CNT_W'(CLKS_PER_BIT - 1);
                busy_o <= 1'b1;
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else if (left == 4'd0) begin
            busy_o <= 1'b0;
        end else begin
            tx_o <= sh[0];
            sh   <= {1'b1, sh[9:1]};
            left <= left - 1'b1;
            cnt  <= CNT_W'(CLKS_PER_BIT - 1);
        end
    end

endmodule

// File: rtl/radio_clock_responder.sv
module radio_clock_responder
    import rcs_pkg::*;
#(
    parameter int CLKS_PER_BIT = 166667
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_i,
    output logic        tx_o,
    input  logic        tick_i,
    input  logic        load_i,
    input  logic [51:0] time_bcd_i,
    input  logic        bst_i,
    input  logic        zone_change_i,
    input  logic        low_batt_i,
    input  logic        last_fail_i,
    input  logic        rx_ok_today_i,
    input  logic        time_valid_i
);
    ctl_state_t           state, nxt;
    clk_rec_t             live, snap;
    logic [IDX_W-1:0]     reply_idx;
    logic                 cmd_seen;
    logic                 echo_pend;
    logic [DATA_BITS-1:0] echo_char;

    logic                 rx_valid;
    logic [DATA_BITS-1:0] rx_data;
    logic                 tx_busy;
    logic                 tx_start;
    logic [DATA_BITS-1:0] tx_data;
    logic                 take_snap, idx_inc, echo_take;
    logic                 query_hit;

    rcs_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .valid_o(rx_valid), .data_o(rx_data)
    );

    rcs_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst_n(rst_n), .start_i(tx_start), .data_i(tx_data),
        .tx_o(tx_o), .busy_o(tx_busy)
    );

    assign query_hit = rx_valid && (rx_data == CR_CODE) && cmd_seen;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next state and control outputs
    always_comb begin
        nxt       = state;
        tx_start  = 1'b0;
        tx_data   = echo_char;
        take_snap = 1'b0;
        idx_inc   = 1'b0;
        echo_take = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (query_hit) begin
                    nxt = S_WAIT;
                end else if (echo_pend) begin
                    tx_start  = 1'b1;
                    echo_take = 1'b1;
                    nxt       = S_ECHO;
                end
            end
            S_ECHO: begin
                if (query_hit)     nxt = tx_busy ? S_WAIT_ECHO : S_WAIT;
                else if (!tx_busy) nxt = S_IDLE;
            end
            S_WAIT: begin
                if (tick_i) begin
                    tx_start  = 1'b1;
                    tx_data   = reply_char(live, '0);
                    take_snap = 1'b1;
                    nxt       = S_REPLY;
                end else if (echo_pend) begin
                    tx_start  = 1'b1;
                    echo_take = 1'b1;
                    nxt       = S_WAIT_ECHO;
                end
            end
            S_WAIT_ECHO: begin
                if (!tx_busy) nxt = S_WAIT;
            end
            S_REPLY: begin
                if (!tx_busy) begin
                    if (reply_idx == IDX_W'(REPLY_CHARS)) begin
                        nxt = S_IDLE;
                    end else begin
                        tx_start = 1'b1;
                        tx_data  = reply_char(snap, reply_idx);
                        idx_inc  = 1'b1;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live      <= '0;
            snap      <= '0;
            reply_idx <= '0;
            cmd_seen  <= 1'b0;
            echo_pend <= 1'b0;
            echo_char <= '0;
        end else begin
            if (load_i)
                live <= '{bcd: time_bcd_i, bst: bst_i, change: zone_change_i,
                          low_batt: low_batt_i, last_fail: last_fail_i,
                          ok_today: rx_ok_today_i, valid: time_valid_i};
            if (take_snap) begin
                snap      <= live;
                reply_idx <= IDX_W'(1);
            end else if (idx_inc) begin
                reply_idx <= reply_idx + 1'b1;
            end
            if (rx_valid) begin
                cmd_seen  <= (rx_data[3:0] == 4'hF);
                echo_char <= rx_data;
                echo_pend <= 1'b1;
            end else if (echo_take) begin
                echo_pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/radio_clock_responder_chk.sv
module radio_clock_responder_chk
    import rcs_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             tx_o,
    input logic             tx_busy,
    input ctl_state_t       state,
    input clk_rec_t         snap,
    input logic [IDX_W-1:0] reply_idx
);
    // R5: the reply begins only on a sampled tick
    a_r5_reply_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPLY && $past(state) != S_REPLY) |-> $past(tick_i));

    // R5: the start bit is on the line in the first reply cycle
    a_r5_start_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPLY && $past(state) == S_WAIT) |-> !tx_o);

    // R10: an armed query behind an echo never jumps straight into the reply
    a_r10_echo_defers: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT_ECHO) |=> (state != S_REPLY));

    // R11: the snapshot is frozen while the reply runs
    a_r11_snap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REPLY && $past(state) == S_REPLY) |-> $stable(snap));

    // R2: the idle line stays high
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_o);

    // R6: the reply never sends more than sixteen characters
    a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        reply_idx <= IDX_W'(REPLY_CHARS));

endmodule

bind radio_clock_responder radio_clock_responder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tx_o(tx_o), .tx_busy(tx_busy),
    .state(state), .snap(snap), .reply_idx(reply_idx)
);

// File: tb/tb_radio_clock_responder.sv
module tb_radio_clock_responder;
    localparam int CPB = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_i = 1'b1;
    logic        tx_o;
    logic        tick_i = 1'b0;
    logic        load_i = 1'b0;
    logic [51:0] time_bcd_i = '0;
    logic        bst_i = 1'b0, zone_change_i = 1'b0, low_batt_i = 1'b0;
    logic        last_fail_i = 1'b0, rx_ok_today_i = 1'b0, time_valid_i = 1'b0;

    int  checks = 0;
    int  failures = 0;
    bit  finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    radio_clock_responder #(.CLKS_PER_BIT(CPB)) dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tx_o(tx_o), .tick_i(tick_i),
        .load_i(load_i), .time_bcd_i(time_bcd_i), .bst_i(bst_i),
        .zone_change_i(zone_change_i), .low_batt_i(low_batt_i),
        .last_fail_i(last_fail_i), .rx_ok_today_i(rx_ok_today_i),
        .time_valid_i(time_valid_i)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] par8(input logic [6:0] d);
        return {^d, d};
    endfunction

    task automatic expect_char(input logic [6:0] d, input string tag);
        exp_q.push_back(par8(d));
        tag_q.push_back(tag);
    endtask

    // R6 R7 R8: expected reply computed from the stated layout
    task automatic expect_reply(input logic [51:0] bcd, input logic bst, input logic chg,
                                input logic lb, input logic fl, input logic ok, input logic v);
        for (int k = 0; k < 13; k++)
            expect_char(7'h30 + {3'b000, bcd[(12 - k) * 4 +: 4]}, "R6 digit");
        expect_char({4'b0110, ~bst, bst, chg}, "R7 zone");
        expect_char({3'b011, lb, fl, ok, v}, "R8 status");
        expect_char(7'h0D, "R6 final CR");
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [6:0] d);
        logic [10:0] f;
        f = {2'b11, ^d, d, 1'b0};
        for (int b = 0; b < 11; b++) begin
            rx_i = f[b];
            wait_cyc(CPB);
        end
    endtask

    task automatic set_inputs(input logic [51:0] bcd, input logic bst, input logic chg,
                              input logic lb, input logic fl, input logic ok, input logic v);
        time_bcd_i = bcd; bst_i = bst; zone_change_i = chg;
        low_batt_i = lb; last_fail_i = fl; rx_ok_today_i = ok; time_valid_i = v;
    endtask

    task automatic pulse_load();
        load_i = 1'b1;
        wait_cyc(1);
        load_i = 1'b0;
    endtask

    // mode 0: no check, 1: reply must start on this tick, 2: line must stay idle
    task automatic do_tick(input int mode);
        @(negedge clk);
        if (mode != 0) check(tx_o == 1'b1, "R5 line high before tick", tx_o, 1);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        if (mode == 1) check(tx_o == 1'b0, "R5 start bit on tick edge", tx_o, 0);
        if (mode == 2) check(tx_o == 1'b1, "R12 no reply on tick", tx_o, 1);
    endtask

    task automatic drain(input string tag);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    // Line monitor: decodes every transmitted frame and compares in order
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && tx_o == 1'b0) begin
                logic [9:0] bits;
                logic [7:0] ch;
                wait_cyc(CPB / 2 - 1);
                check(tx_o == 1'b0, "R2 start bit", tx_o, 0);
                for (int b = 0; b < 10; b++) begin
                    wait_cyc(CPB);
                    bits[b] = tx_o;
                end
                ch = bits[7:0];
                check(bits[9:8] == 2'b11, "R2 stop bits", bits[9:8], 3);
                check(^ch == 1'b0, "R9 even parity", ch, par8(ch[6:0]));
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected character", ch, 0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(ch == e, t, ch, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        check(tx_o == 1'b1, "R1 idle line after reset", tx_o, 1);

        // R1 R4 R5: query before any load, reply holds reset values
        expect_char(7'h6F, "R3 echo o");
        expect_char(7'h0D, "R3 echo CR");
        send_char(7'h6F);
        send_char(7'h0D);
        wait_cyc(14 * CPB);
        expect_reply('0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        do_tick(1);
        wait_cyc(16 * 12 * CPB);
        drain("R1 reset reply complete");

        // R13 R3 R12: load values, echo plain characters, unarmed tick
        set_inputs(52'h1745395281224, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        pulse_load();
        expect_char(7'h41, "R3 echo A");
        expect_char(7'h07, "R3 echo 07");
        send_char(7'h41);
        send_char(7'h07);
        wait_cyc(14 * CPB);
        do_tick(2);
        wait_cyc(4 * CPB);
        drain("R3 echoes complete");

        // R4: command broken by another character does not arm
        expect_char(7'h6F, "R3 echo o");
        expect_char(7'h78, "R3 echo x");
        expect_char(7'h0D, "R3 echo CR");
        send_char(7'h6F);
        send_char(7'h78);
        send_char(7'h0D);
        wait_cyc(14 * CPB);
        do_tick(2);
        wait_cyc(14 * CPB);
        drain("R4 no reply after broken command");

        // R4 R10: binary command, tick during the CR echo is dropped
        expect_char(7'h0F, "R3 echo 0F");
        expect_char(7'h0D, "R3 echo CR");
        send_char(7'h0F);
        send_char(7'h0D);
        do_tick(0);
        wait_cyc(14 * CPB);
        drain("R10 no reply on tick during echo");

        // R13: inputs changed without a load do not reach the reply
        set_inputs(52'h0812054070399, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        expect_reply(52'h1745395281224, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
        do_tick(1);
        // R11: a load during the reply leaves it unchanged
        wait_cyc(5 * CPB);
        pulse_load();
        wait_cyc(16 * 12 * CPB);
        drain("R11 reply from snapshot complete");

        // R13: the load taken during the reply is used by the next reply
        expect_char(7'h6F, "R3 echo o");
        expect_char(7'h0D, "R3 echo CR");
        send_char(7'h6F);
        send_char(7'h0D);
        wait_cyc(14 * CPB);
        expect_reply(52'h0812054070399, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        do_tick(1);
        wait_cyc(16 * 12 * CPB);
        drain("R13 reply after load complete");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule